// File: doc/BRIEF.md
# Translation Buffer with Page Table Walker

This block translates 32-bit virtual addresses into 32-bit physical addresses for 4 KB pages. It holds a small fully associative buffer of recent page mappings. A requester hands over a virtual address together with a write flag. When the page is in the buffer, the physical address comes back two cycles after acceptance. When the page is missing, the block computes the page table entry address from a base register and the virtual page number, and reads that entry over a single-word request/acknowledge memory port. A valid entry is installed and the lookup is replayed. An invalid entry ends as a page fault, and a write to a read-only page ends as a protection fault.

The base register stands for the current address space. Writing it flushes every buffer entry, which models a context switch. If the base register is written while a walk is outstanding, the fetched entry is thrown away and the walk is repeated with the new base. Victims are picked with a clock policy that keeps one use bit per entry. `ENTRIES` must be a power of two, at least 2.

Top module: `tlb_walker`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` and `mem_req_o` are 0, and all buffer entries are empty, so the first request of any page walks (`rsp_walked_o` = 1).
- R2: A request whose page is held in the buffer responds with `rsp_valid_o` high in the cycle after the second rising edge following acceptance, with `rsp_walked_o` = 0, status 0 (ok) and `rsp_paddr_o` = {stored physical page number, virtual address bits 11:0}.
- R3: On a miss the block raises `mem_req_o` with `mem_addr_o` = base + (virtual page number << 2), and holds both stable until `mem_ack_i`. A hit issues no memory read.
- R4: The entry read on `mem_rdata_i` has bit 31 = valid, bit 30 = writable and bits 19:0 = physical page number, with all other bits ignored. A valid entry is installed and the lookup is replayed, and the response then carries `rsp_walked_o` = 1. No page appears twice in the buffer.
- R5: An entry with bit 31 clear gives status 1 (page fault) with `rsp_paddr_o` = 0 and installs nothing, so a repeat of the same request walks again.
- R6: A write request to a page whose entry has bit 30 clear gives status 2 (protection fault) with `rsp_paddr_o` = 0, both on a hit and after a refill. A read of such a page succeeds. Status 3 never occurs.
- R7: A pulse on `base_we_i` loads `base_wdata_i` into the base register and empties every entry at the same clock edge.
- R8: A base write while a walk is outstanding discards the entry that is returned, then walks again at the address formed from the new base.
- R9: The buffer holds `ENTRIES` pages (default 8). A hit sets the entry's use bit, and the clock hand survives a flush. On a fill, the hand moves forward from its position, clearing set use bits until it reaches a clear one. That entry is the victim (when all use bits are set, the entry at the hand is the victim after a full sweep). The hand then points one past the victim.
- R10: `rsp_valid_o` is a single-cycle pulse, and `req_ready_o` is high only when no request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Block idle, request taken this cycle |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Request is a write access |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | 32 | Physical address, zero on faults |
| rsp_status_o | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| rsp_walked_o | output | 1 | A page table read preceded this response |
| base_we_i | input | 1 | Base register write and flush |
| base_wdata_i | input | 32 | New page table base |
| mem_req_o | output | 1 | Page table read request |
| mem_addr_o | output | 32 | Page table entry address |
| mem_ack_i | input | 1 | Read data valid, ends the request |
| mem_rdata_i | input | 32 | Page table entry |

## Verification
A random stream over a pool of twelve pages, larger than the buffer, mixes reads and writes, random offsets, random memory latency and occasional base changes. Each response is compared with a reference model of the buffer and its clock hand, which separates hit from refill and exposes a wrong victim as an unexpected walk. Directed cases cover invalid and read-only entries on both the hit and the refill path, the flush, and a base write landing mid-walk, where only a second read at the new address is accepted. A fill-all-then-evict sequence checks which resident page the clock hand removes.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned VPN_W     = VA_W - OFF_W;
  localparam int unsigned PPN_W     = 20;
  localparam int unsigned PA_W      = PPN_W + OFF_W;
  localparam int unsigned PTE_W     = 32;
  localparam int unsigned PTE_V_BIT = 31;
  localparam int unsigned PTE_W_BIT = 30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_WALK_REQ, ST_WALK_WAIT, ST_FILL, ST_RESP
  } tlb_state_e;

  typedef enum logic [1:0] {
    RSP_OK         = 2'd0,
    RSP_PAGE_FAULT = 2'd1,
    RSP_PROT_FAULT = 2'd2
  } tlb_status_e;
endpackage

// File: rtl/tlb_cam.sv
`timescale 1ns/1ps
module tlb_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       fill_i,
  input  logic [$clog2(ENTRIES)-1:0] fill_idx_i,
  input  logic [VPN_W-1:0]           fill_vpn_i,
  input  logic [PPN_W-1:0]           fill_ppn_i,
  input  logic                       fill_wr_i,
  input  logic [VPN_W-1:0]           lookup_vpn_i,
  output logic [ENTRIES-1:0]         hit_vec_o,
  output logic                       hit_o,
  output logic [$clog2(ENTRIES)-1:0] hit_idx_o,
  output logic [PPN_W-1:0]           hit_ppn_o,
  output logic                       hit_wr_o,
  output logic [ENTRIES-1:0]         valid_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [PPN_W-1:0]   ppn_arr [ENTRIES];
  logic [ENTRIES-1:0] wr_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic             v_q;
    logic [VPN_W-1:0] tag_q;
    logic [PPN_W-1:0] ppn_q;
    logic             wr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q   <= 1'b0;
        tag_q <= '0;
        ppn_q <= '0;
        wr_q  <= 1'b0;
      end else if (flush_i) begin
        v_q <= 1'b0;
      end else if (fill_i && fill_idx_i == IDX_W'(e)) begin
        v_q   <= 1'b1;
        tag_q <= fill_vpn_i;
        ppn_q <= fill_ppn_i;
        wr_q  <= fill_wr_i;
      end
    end

    assign hit_vec_o[e] = v_q && (tag_q == lookup_vpn_i);
    assign ppn_arr[e]   = ppn_q;
    assign wr_vec[e]    = wr_q;
    assign valid_o[e]   = v_q;
  end

  always_comb begin
    hit_idx_o = '0;
    hit_ppn_o = '0;
    hit_wr_o  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec_o[i]) begin
        hit_idx_o = IDX_W'(i);
        hit_ppn_o = hit_ppn_o | ppn_arr[i];
        hit_wr_o  = hit_wr_o | wr_vec[i];
      end
    end
  end

  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/tlb_clock.sv
`timescale 1ns/1ps
module tlb_clock #(
  parameter int unsigned ENTRIES = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       touch_i,
  input  logic [$clog2(ENTRIES)-1:0] touch_idx_i,
  input  logic                       alloc_i,
  output logic [$clog2(ENTRIES)-1:0] victim_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] use_q;
  logic [ENTRIES-1:0] sweep_clr;
  logic [IDX_W-1:0]   hand_q;
  logic               found;

  // Sweep from the hand; every set bit passed before the first clear one is cleared.
  always_comb begin
    found     = 1'b0;
    victim_o  = hand_q;
    sweep_clr = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      logic [IDX_W-1:0] idx;
      idx = hand_q + IDX_W'(k);
      if (!found) begin
        if (!use_q[idx]) begin
          found    = 1'b1;
          victim_o = idx;
        end else begin
          sweep_clr[idx] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      use_q  <= '0;
      hand_q <= '0;
    end else if (flush_i) begin
      use_q <= '0;
    end else if (alloc_i) begin
      use_q           <= use_q & ~sweep_clr;
      use_q[victim_o] <= 1'b0;
      hand_q          <= victim_o + IDX_W'(1);
    end else if (touch_i) begin
      use_q[touch_idx_i] <= 1'b1;
    end
  end
endmodule

// File: rtl/tlb_ctrl.sv
`timescale 1ns/1ps
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [1:0]       rsp_status_o,
  output logic             rsp_walked_o,
  input  logic             base_we_i,
  input  logic [VA_W-1:0]  base_wdata_i,
  output logic             mem_req_o,
  output logic [VA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic [VPN_W-1:0] lookup_vpn_o,
  input  logic             hit_i,
  input  logic [PPN_W-1:0] hit_ppn_i,
  input  logic             hit_wr_i,
  output logic             touch_o,
  output logic             fill_o,
  output logic [PPN_W-1:0] fill_ppn_o,
  output logic             fill_wr_o
);
  tlb_state_e        state_q;
  logic [VA_W-1:0]   vaddr_q;
  logic              write_q;
  logic [VA_W-1:0]   base_q;
  logic [VA_W-1:0]   base_nxt;
  logic [VA_W-1:0]   pte_addr;
  logic [VA_W-1:0]   walk_addr_q;
  logic              pte_v_q;
  logic              pte_w_q;
  logic [PPN_W-1:0]  pte_ppn_q;
  logic              stale_q;
  logic              walked_q;
  logic              redo;
  tlb_status_e       status_q;
  logic [PA_W-1:0]   paddr_q;
  logic              unused_pte;

  assign unused_pte = ^mem_rdata_i[PTE_W_BIT-1:PPN_W];

  assign base_nxt     = base_we_i ? base_wdata_i : base_q;
  assign lookup_vpn_o = vaddr_q[VA_W-1:OFF_W];
  assign pte_addr     = base_nxt + VA_W'({lookup_vpn_o, 2'b00});
  assign redo         = stale_q || base_we_i;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = (state_q == ST_RESP);
  assign rsp_paddr_o  = paddr_q;
  assign rsp_status_o = status_q;
  assign rsp_walked_o = walked_q;
  assign mem_req_o    = (state_q == ST_WALK_REQ) || (state_q == ST_WALK_WAIT);
  assign mem_addr_o   = walk_addr_q;

  assign touch_o    = (state_q == ST_LOOKUP) && hit_i;
  assign fill_o     = (state_q == ST_FILL) && !redo && pte_v_q;
  assign fill_ppn_o = pte_ppn_q;
  assign fill_wr_o  = pte_w_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (base_we_i) begin
      base_q <= base_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      vaddr_q     <= '0;
      write_q     <= 1'b0;
      walk_addr_q <= '0;
      pte_v_q     <= 1'b0;
      pte_w_q     <= 1'b0;
      pte_ppn_q   <= '0;
      stale_q     <= 1'b0;
      walked_q    <= 1'b0;
      status_q    <= RSP_OK;
      paddr_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            vaddr_q  <= req_vaddr_i;
            write_q  <= req_write_i;
            walked_q <= 1'b0;
            state_q  <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit_i) begin
            if (write_q && !hit_wr_i) begin
              status_q <= RSP_PROT_FAULT;
              paddr_q  <= '0;
            end else begin
              status_q <= RSP_OK;
              paddr_q  <= {hit_ppn_i, vaddr_q[OFF_W-1:0]};
            end
            state_q <= ST_RESP;
          end else begin
            walk_addr_q <= pte_addr;
            stale_q     <= 1'b0;
            state_q     <= ST_WALK_REQ;
          end
        end
        ST_WALK_REQ, ST_WALK_WAIT: begin
          if (base_we_i) stale_q <= 1'b1;
          if (mem_ack_i) begin
            pte_v_q   <= mem_rdata_i[PTE_V_BIT];
            pte_w_q   <= mem_rdata_i[PTE_W_BIT];
            pte_ppn_q <= mem_rdata_i[PPN_W-1:0];
            state_q   <= ST_FILL;
          end else begin
            state_q <= ST_WALK_WAIT;
          end
        end
        ST_FILL: begin
          if (redo) begin
            // Entry was read under an old base: fetch again.
            walk_addr_q <= pte_addr;
            stale_q     <= 1'b0;
            state_q     <= ST_WALK_REQ;
          end else if (!pte_v_q) begin
            status_q <= RSP_PAGE_FAULT;
            paddr_q  <= '0;
            walked_q <= 1'b1;
            state_q  <= ST_RESP;
          end else begin
            walked_q <= 1'b1;
            state_q  <= ST_LOOKUP;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlb_walker.sv
`timescale 1ns/1ps
module tlb_walker
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [1:0]       rsp_status_o,
  output logic             rsp_walked_o,
  input  logic             base_we_i,
  input  logic [VA_W-1:0]  base_wdata_i,
  output logic             mem_req_o,
  output logic [VA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]   lookup_vpn;
  logic               hit;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] ent_valid;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim;
  logic [PPN_W-1:0]   hit_ppn;
  logic               hit_wr;
  logic               touch;
  logic               fill;
  logic [PPN_W-1:0]   fill_ppn;
  logic               fill_wr;

  tlb_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_vaddr_i  (req_vaddr_i),
    .req_write_i  (req_write_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_paddr_o  (rsp_paddr_o),
    .rsp_status_o (rsp_status_o),
    .rsp_walked_o (rsp_walked_o),
    .base_we_i    (base_we_i),
    .base_wdata_i (base_wdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .lookup_vpn_o (lookup_vpn),
    .hit_i        (hit),
    .hit_ppn_i    (hit_ppn),
    .hit_wr_i     (hit_wr),
    .touch_o      (touch),
    .fill_o       (fill),
    .fill_ppn_o   (fill_ppn),
    .fill_wr_o    (fill_wr)
  );

  tlb_cam #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_cam (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (base_we_i),
    .fill_i       (fill),
    .fill_idx_i   (victim),
    .fill_vpn_i   (lookup_vpn),
    .fill_ppn_i   (fill_ppn),
    .fill_wr_i    (fill_wr),
    .lookup_vpn_i (lookup_vpn),
    .hit_vec_o    (hit_vec),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx),
    .hit_ppn_o    (hit_ppn),
    .hit_wr_o     (hit_wr),
    .valid_o      (ent_valid)
  );

  tlb_clock #(
    .ENTRIES (ENTRIES)
  ) u_clock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (base_we_i),
    .touch_i     (touch),
    .touch_idx_i (hit_idx),
    .alloc_i     (fill),
    .victim_o    (victim)
  );
endmodule

// File: rtl/tlb_walker_chk.sv
`timescale 1ns/1ps
module tlb_walker_chk #(
  parameter int unsigned ENTRIES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [11:0]        acc_off_i,
  input logic               rsp_valid_o,
  input logic [31:0]        rsp_paddr_o,
  input logic [1:0]         rsp_status_o,
  input logic               base_we_i,
  input logic               mem_req_o,
  input logic               mem_ack_i,
  input logic [31:0]        mem_addr_o,
  input logic [ENTRIES-1:0] ent_valid_i,
  input logic [ENTRIES-1:0] hit_vec_i
);
  logic [11:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= '0;
    else if (req_valid_i && req_ready_o) off_q <= acc_off_i;
  end

  assert_rsp_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_ready_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!rsp_valid_o && !mem_req_o));

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_offset_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == 2'd0) |-> (rsp_paddr_o[11:0] == off_q));

  assert_fault_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != 2'd0) |-> (rsp_paddr_o == '0));

  assert_status_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_status_o != 2'd3));

  assert_flush_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_i |=> (ent_valid_i == '0));

  assert_no_dup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i));
endmodule

bind tlb_walker tlb_walker_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .acc_off_i    (req_vaddr_i[11:0]),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_paddr_o  (rsp_paddr_o),
  .rsp_status_o (rsp_status_o),
  .base_we_i    (base_we_i),
  .mem_req_o    (mem_req_o),
  .mem_ack_i    (mem_ack_i),
  .mem_addr_o   (mem_addr_o),
  .ent_valid_i  (ent_valid),
  .hit_vec_i    (hit_vec)
);

// File: tb/tlb_walker_tb_top.sv
`timescale 1ns/1ps
module tlb_walker_tb_top;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_status;
  logic        rsp_walked;
  logic        base_we = 1'b0;
  logic [31:0] base_wd = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  tlb_walker #(.ENTRIES(NE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
    .rsp_status_o(rsp_status), .rsp_walked_o(rsp_walked),
    .base_we_i(base_we), .base_wdata_i(base_wd),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Page table contents: a fixed hash of the entry address (bit31 valid, bit30 writable, 19:0 page).
  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [31:0] h;
    h = (a ^ 32'h5bd1e995) * 32'h9e3779b1;
    h = h ^ (h >> 13);
    return {h[31] | h[7] | h[6], h[30:0]};
  endfunction

  // ---------------- memory responder ----------------
  int          mem_force = -1;
  int          n_acks = 0;
  logic [31:0] last_addr = '0;

  initial begin
    bit          busy;
    int          cnt;
    logic [31:0] cap;
    busy = 0; cnt = 0; cap = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (!busy) begin
          busy = 1;
          cap  = mem_addr;
          cnt  = (mem_force >= 0) ? mem_force : int'($urandom % 4);
        end
        if (cnt == 0) begin
          mem_ack   = 1'b1;
          mem_rdata = pte_of(cap);
          last_addr = cap;
          n_acks++;
          busy = 0;
        end else begin
          cnt--;
        end
      end
    end
  end

  // ---------------- reference model ----------------
  bit          m_v [NE];
  logic [19:0] m_t [NE];
  logic [19:0] m_p [NE];
  bit          m_w [NE];
  bit          m_u [NE];
  int          m_hand = 0;
  logic [31:0] m_base = '0;

  task automatic m_flush();
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_u[i] = 0; end
  endtask

  function automatic int m_find(input logic [19:0] vpn);
    for (int i = 0; i < NE; i++) if (m_v[i] && m_t[i] == vpn) return i;
    return -1;
  endfunction

  task automatic m_alloc(input logic [19:0] vpn, input logic [19:0] ppn, input bit wr);
    int v;
    v = -1;
    for (int k = 0; k < NE; k++) begin
      int i;
      i = (m_hand + k) % NE;
      if (v < 0) begin
        if (!m_u[i]) v = i;
        else m_u[i] = 0;
      end
    end
    if (v < 0) v = m_hand;
    m_v[v] = 1; m_t[v] = vpn; m_p[v] = ppn; m_w[v] = wr; m_u[v] = 0;
    m_hand = (v + 1) % NE;
  endtask

  task automatic expect_req(input logic [31:0] va, input bit wr, output bit e_walk,
                            output logic [1:0] e_st, output logic [31:0] e_pa, output logic [31:0] e_addr);
    logic [19:0] vpn;
    logic [31:0] pte;
    int i;
    vpn = va[31:12];
    e_addr = m_base + {10'b0, vpn, 2'b00};
    e_walk = 0;
    i = m_find(vpn);
    if (i < 0) begin
      e_walk = 1;
      pte = pte_of(e_addr);
      if (!pte[31]) begin
        e_st = 2'd1; e_pa = '0;
        return;
      end
      m_alloc(vpn, pte[19:0], pte[30]);
      i = m_find(vpn);
    end
    m_u[i] = 1;
    if (wr && !m_w[i]) begin e_st = 2'd2; e_pa = '0; end
    else begin e_st = 2'd0; e_pa = {m_p[i], va[11:0]}; end
  endtask

  // ---------------- drivers ----------------
  task automatic base_write(input logic [31:0] nb);
    @(negedge clk);
    base_we = 1'b1; base_wd = nb;
    @(negedge clk);
    base_we = 1'b0;
    m_flush();
    m_base = nb;
  endtask

  bit last_walked;

  task automatic run_req(input logic [31:0] va, input bit wr, input string tag,
                         input bit mid = 0, input logic [31:0] nb = '0);
    bit          e_walk, fired;
    logic [1:0]  e_st;
    logic [31:0] e_pa, e_addr;
    int          acks0, lat;
    fired = 0;
    if (mid) begin m_flush(); m_base = nb; mem_force = 4; end
    expect_req(va, wr, e_walk, e_st, e_pa, e_addr);
    acks0 = n_acks;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    chk(req_ready == 1'b0, "R10", req_ready, 0);
    while (!rsp_valid) begin
      if (mid && !fired && mem_req) begin base_we = 1'b1; base_wd = nb; fired = 1; end
      @(negedge clk);
      base_we = 1'b0;
      lat++;
    end
    mem_force = -1;
    last_walked = rsp_walked;
    chk(rsp_status == e_st, tag, rsp_status, e_st);
    chk(rsp_paddr == e_pa, tag, rsp_paddr, e_pa);
    chk(rsp_walked == e_walk, tag, rsp_walked, e_walk);
    if (e_walk) begin
      chk(n_acks - acks0 == (mid ? 2 : 1), mid ? "R8" : "R3", n_acks - acks0, mid ? 2 : 1);
      chk(last_addr == e_addr, mid ? "R8" : "R3", last_addr, e_addr);
    end else begin
      chk(n_acks == acks0, "R3", n_acks - acks0, 0);
      chk(lat == 2, "R2", lat, 2);
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10", {rsp_valid, req_ready}, 2'b01);
  endtask

  // kind: 0 invalid, 1 valid read-only, 2 valid writable, 3 any valid
  function automatic logic [19:0] find_vpn(input logic [31:0] b, input logic [19:0] start, input int kind);
    for (int n = 0; n < 4096; n++) begin
      logic [19:0] v;
      logic [31:0] p;
      v = start + 20'(n);
      p = pte_of(b + {10'b0, v, 2'b00});
      if (kind == 0 && !p[31]) return v;
      if (kind == 1 && p[31] && !p[30]) return v;
      if (kind == 2 && p[31] && p[30]) return v;
      if (kind == 3 && p[31]) return v;
    end
    return start;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] b0, b1, b2;
    logic [19:0] vw, vi, vr;
    logic [19:0] pg [9];
    void'($urandom(32'd20241211));
    b0 = 32'h0010_0000; b1 = 32'h0020_0000; b2 = 32'h0030_4000;
    m_flush();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", rsp_valid, 0);
    chk(mem_req == 1'b0, "R1", mem_req, 0);

    // R1: empty after reset, base register resets to zero
    vw = find_vpn('0, 20'h00040, 2);
    run_req({vw, 12'h010}, 1'b0, "R1");
    chk(last_walked == 1'b1, "R1", last_walked, 1);

    base_write(b0);
    vw = find_vpn(b0, 20'h00100, 2);
    run_req({vw, 12'h123}, 1'b0, "R4");
    run_req({vw, 12'habc}, 1'b1, "R2");
    run_req({vw, 12'hfff}, 1'b0, "R2");

    // R5: invalid entry, nothing installed
    vi = find_vpn(b0, 20'h00200, 0);
    run_req({vi, 12'h004}, 1'b0, "R5");
    run_req({vi, 12'h008}, 1'b0, "R5");
    chk(last_walked == 1'b1, "R5", last_walked, 1);

    // R6: read-only page, refill and hit paths
    vr = find_vpn(b0, 20'h00300, 1);
    run_req({vr, 12'h100}, 1'b0, "R6");
    run_req({vr, 12'h104}, 1'b1, "R6");
    base_write(b0);
    run_req({vr, 12'h108}, 1'b1, "R6");

    // R7: flush on base write
    run_req({vw, 12'h020}, 1'b0, "R7");
    run_req({vw, 12'h024}, 1'b0, "R7");
    chk(last_walked == 1'b0, "R7", last_walked, 0);
    base_write(b0);
    run_req({vw, 12'h028}, 1'b0, "R7");
    chk(last_walked == 1'b1, "R7", last_walked, 1);

    // R8: base write while the walk is outstanding
    base_write(b1);
    run_req({find_vpn(b2, 20'h00400, 3), 12'h0c0}, 1'b0, "R8", 1'b1, b2);

    // R9: fill all, then evict through a full sweep
    base_write(b0);
    pg[0] = find_vpn(b0, 20'h01000, 3);
    for (int i = 1; i < 9; i++) pg[i] = find_vpn(b0, pg[i-1] + 20'd1, 3);
    for (int i = 0; i < 8; i++) run_req({pg[i], 12'h000}, 1'b0, "R9");
    for (int i = 0; i < 8; i++) begin
      run_req({pg[i], 12'h044}, 1'b0, "R9");
      chk(last_walked == 1'b0, "R9", last_walked, 0);
    end
    run_req({pg[8], 12'h000}, 1'b0, "R9");
    run_req({pg[1], 12'h000}, 1'b0, "R9");
    chk(last_walked == 1'b0, "R9", last_walked, 0);
    run_req({pg[0], 12'h000}, 1'b0, "R9");
    chk(last_walked == 1'b1, "R9", last_walked, 1);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [19:0] v;
      v = 20'h00100 + 20'($urandom % 12);
      if ($urandom % 40 == 0) begin
        case ($urandom % 3)
          0: base_write(b0);
          1: base_write(b1);
          default: base_write(b2);
        endcase
      end
      run_req({v, 12'($urandom % 4096)}, 1'($urandom % 2), "R4");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule